// File: doc/BRIEF.md
# Strip-Mined Vector Loop Sequencer

This block steers a loop that is vectorised through memory. The loop counter sets the vector length for each pass. An instruction decoder reports four kinds of event to the block. The first is a setup command, which marks some architectural registers as vectors and others as loop-invariant. The second is a register write. The third is a write of the loop counter. The fourth is the decrement-and-branch that closes the loop. The setup command does not start vector execution. Vector mode starts with the first write to a register tagged as a vector. At that point every per-register offset tracker is cleared. From then on each tracker holds the byte offset of element 0 for the current pass.

While the block is active, each pass covers min(MAXVL, counter) elements. The block outputs a lane-enable mask and one byte offset per lane for a register chosen on a query port. When the loop branch arrives, the counter drops by the pass length and the trackers move forward. The branch is taken only if elements remain. When it falls through, vector mode ends and scalar operation resumes. A setup command that arrives in the middle of a loop aborts the loop and raises an error pulse.

Top module: `vloop_seq`

## Requirements
- R1: After reset the block is inactive, with `vl`=0, `lane_en`=0, `ctr_out`=0, `err`=0 and `br_taken`=0.
- R2: A setup while inactive stores the vector and invariant tags and does not activate the block. A register marked both vector and invariant counts as invariant only, so `q_is_vec`=0 and its query base reads 0.
- R3: While inactive, a write to a vector-tagged register makes `active` 1 from the next cycle. A write to an untagged or invariant register leaves the block inactive.
- R4: On activation every offset tracker is cleared, so the queried register's base offset is 0 on the first pass.
- R5: `vl` equals min(MAXVL, `ctr_out`) while active and 0 while inactive.
- R6: Bit i of `lane_en` is 1 exactly when i < `vl`.
- R7: The offset field for lane i is bits [i*OFF_W +: OFF_W] of `lane_off`. It equals the queried register's base plus i*ELEM_BYTES. With the default 4-byte elements, the first four lanes read 0, 4, 8 and 12 on the first pass.
- R8: During a `br_valid` cycle while active, `br_taken` is 1 exactly when `ctr_out` differs from `vl`. From the next cycle `ctr_out` equals its old value minus `vl`.
- R9: A taken branch advances the tracker of every vector-tagged register by `vl`*ELEM_BYTES. For example, MAXVL=20 with a counter of 32 gives a pass of 20 followed by a pass of 12, and the second pass starts at base 80.
- R10: A branch that is not taken makes the block inactive from the next cycle. The tags are kept.
- R11: A setup while active makes the block inactive from the next cycle and clears all tags. It raises `err` for exactly that one cycle.
- R12: A counter write while active is ignored. A branch while inactive is ignored: `br_taken` stays 0 and `ctr_out` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_valid | input | 1 | Setup command |
| setup_vec_mask | input | NREG | Registers to tag as vectors |
| setup_inv_mask | input | NREG | Registers to flag as loop-invariant |
| wr_valid | input | 1 | Register write reported by the decoder |
| wr_reg | input | IDX_W | Index of the written register |
| ctr_wr_valid | input | 1 | Scalar write of the loop counter |
| ctr_wr_data | input | CTR_W | Loop counter value |
| br_valid | input | 1 | Loop-closing decrement-and-branch |
| q_reg | input | IDX_W | Register whose offsets are shown |
| active | output | 1 | Vector mode is on |
| vl | output | VL_W | Vector length of the current pass |
| lane_en | output | MAXVL | Per-lane enable mask |
| lane_off | output | MAXVL*OFF_W | Per-lane byte offsets for `q_reg` |
| q_is_vec | output | 1 | `q_reg` is tagged as a vector |
| br_taken | output | 1 | Branch decision, valid during `br_valid` |
| ctr_out | output | CTR_W | Loop counter |
| err | output | 1 | One-cycle pulse after a setup that aborts a loop |

## Verification
The assertions assume the decoder reports at most one event in a cycle. Setup takes priority over branch, branch over write, and write over counter write. The assertions also assume that the counter holds its value between branches inside a pass. The stimulus raises one strobe at a time, on the falling edge, and holds it for a single cycle. Before each loop it loads the counter while the block is inactive. This keeps every counter change inside the sequencer's own decrement path.

// File: rtl/vloop_pkg.sv
package vloop_pkg;
  typedef enum logic [1:0] {
    VS_IDLE   = 2'd0,
    VS_ARMED  = 2'd1,
    VS_ACTIVE = 2'd2
  } vstate_e;
endpackage

// File: rtl/vloop_vl_calc.sv
module vloop_vl_calc #(
  parameter int MAXVL = 20,
  parameter int CTR_W = 16,
  localparam int VL_W = $clog2(MAXVL + 1)
) (
  input  logic             active,
  input  logic [CTR_W-1:0] ctr,
  output logic [VL_W-1:0]  vl,
  output logic [MAXVL-1:0] lane_en
);
  always_comb begin
    if (!active) begin
      vl = '0;
    end else if (ctr >= CTR_W'(MAXVL)) begin
      vl = VL_W'(MAXVL);
    end else begin
      vl = ctr[VL_W-1:0];
    end
  end

  for (genvar i = 0; i < MAXVL; i++) begin : g_lane
    assign lane_en[i] = (VL_W'(i) < vl);
  end
endmodule

// File: rtl/vloop_ctrl.sv
module vloop_ctrl
  import vloop_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int CTR_W = 16,
  parameter int MAXVL = 20,
  localparam int IDX_W = $clog2(NREG),
  localparam int VL_W  = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_valid,
  input  logic [NREG-1:0]  setup_vec_mask,
  input  logic [NREG-1:0]  setup_inv_mask,
  input  logic             wr_valid,
  input  logic [IDX_W-1:0] wr_reg,
  input  logic             ctr_wr_valid,
  input  logic [CTR_W-1:0] ctr_wr_data,
  input  logic             br_valid,
  input  logic [VL_W-1:0]  vl,
  output logic             active,
  output logic [NREG-1:0]  vec_tag,
  output logic [CTR_W-1:0] ctr_q,
  output logic             trk_clr,
  output logic             trk_adv,
  output logic             br_taken,
  output logic             err
);
  vstate_e          state_q, state_d;
  logic [NREG-1:0]  vtag_q, vtag_d, itag_q, itag_d;
  logic [CTR_W-1:0] ctr_d;
  logic             err_d;
  logic             tag_en, ctr_en;
  logic             hit;
  logic [CTR_W-1:0] vl_ext;

  assign active = (state_q == VS_ACTIVE);
  assign vl_ext = CTR_W'(vl);
  assign hit    = wr_valid && vtag_q[wr_reg];
  assign br_taken = br_valid && active && !setup_valid && (ctr_q != vl_ext);

  always_comb begin
    state_d = state_q;
    vtag_d  = vtag_q;
    itag_d  = itag_q;
    ctr_d   = ctr_q;
    err_d   = 1'b0;
    tag_en  = 1'b0;
    ctr_en  = 1'b0;
    trk_clr = 1'b0;
    trk_adv = 1'b0;
    if (setup_valid) begin
      tag_en = 1'b1;
      if (active) begin
        state_d = VS_IDLE;
        vtag_d  = '0;
        itag_d  = '0;
        err_d   = 1'b1;
      end else begin
        vtag_d  = setup_vec_mask & ~setup_inv_mask;
        itag_d  = setup_inv_mask;
        state_d = (|(setup_vec_mask & ~setup_inv_mask)) ? VS_ARMED : VS_IDLE;
      end
    end else if (active && br_valid) begin
      ctr_en = 1'b1;
      ctr_d  = ctr_q - vl_ext;
      if (br_taken) begin
        trk_adv = 1'b1;
      end else begin
        state_d = VS_ARMED;
      end
    end else if (!active && hit) begin
      state_d = VS_ACTIVE;
      trk_clr = 1'b1;
    end else if (!active && ctr_wr_valid) begin
      ctr_en = 1'b1;
      ctr_d  = ctr_wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= VS_IDLE;
      err     <= 1'b0;
    end else begin
      state_q <= state_d;
      err     <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vtag_q <= '0;
      itag_q <= '0;
    end else if (tag_en) begin
      vtag_q <= vtag_d;
      itag_q <= itag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q <= '0;
    end else if (ctr_en) begin
      ctr_q <= ctr_d;
    end
  end

  assign vec_tag = vtag_q & ~itag_q;
endmodule

// File: rtl/vloop_trackers.sv
module vloop_trackers #(
  parameter int NREG       = 32,
  parameter int OFF_W      = 16,
  parameter int MAXVL      = 20,
  parameter int ELEM_BYTES = 4,
  localparam int IDX_W = $clog2(NREG),
  localparam int VL_W  = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [VL_W-1:0]  vl,
  input  logic [NREG-1:0]  vec_tag,
  input  logic [IDX_W-1:0] q_reg,
  output logic [OFF_W-1:0] q_base
);
  logic [OFF_W-1:0] base_q [NREG];
  logic [OFF_W-1:0] step;

  assign step = OFF_W'(vl) * OFF_W'(ELEM_BYTES);

  for (genvar r = 0; r < NREG; r++) begin : g_trk
    logic en;
    assign en = clr || (adv && vec_tag[r]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[r] <= '0;
      end else if (en) begin
        base_q[r] <= clr ? '0 : (base_q[r] + step);
      end
    end
  end

  assign q_base = vec_tag[q_reg] ? base_q[q_reg] : '0;
endmodule

// File: rtl/vloop_seq.sv
module vloop_seq #(
  parameter int NREG       = 32,
  parameter int MAXVL      = 20,
  parameter int CTR_W      = 16,
  parameter int OFF_W      = 16,
  parameter int ELEM_BYTES = 4,
  localparam int IDX_W = $clog2(NREG),
  localparam int VL_W  = $clog2(MAXVL + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   setup_valid,
  input  logic [NREG-1:0]        setup_vec_mask,
  input  logic [NREG-1:0]        setup_inv_mask,
  input  logic                   wr_valid,
  input  logic [IDX_W-1:0]       wr_reg,
  input  logic                   ctr_wr_valid,
  input  logic [CTR_W-1:0]       ctr_wr_data,
  input  logic                   br_valid,
  input  logic [IDX_W-1:0]       q_reg,
  output logic                   active,
  output logic [VL_W-1:0]        vl,
  output logic [MAXVL-1:0]       lane_en,
  output logic [MAXVL*OFF_W-1:0] lane_off,
  output logic                   q_is_vec,
  output logic                   br_taken,
  output logic [CTR_W-1:0]       ctr_out,
  output logic                   err
);
  logic [NREG-1:0]  vec_tag;
  logic             trk_clr, trk_adv;
  logic [OFF_W-1:0] q_base;

  vloop_ctrl #(.NREG(NREG), .CTR_W(CTR_W), .MAXVL(MAXVL)) ctrl_i (
    .clk, .rst_n, .setup_valid, .setup_vec_mask, .setup_inv_mask,
    .wr_valid, .wr_reg, .ctr_wr_valid, .ctr_wr_data, .br_valid,
    .vl, .active, .vec_tag, .ctr_q(ctr_out), .trk_clr, .trk_adv,
    .br_taken, .err
  );

  vloop_vl_calc #(.MAXVL(MAXVL), .CTR_W(CTR_W)) vl_i (
    .active, .ctr(ctr_out), .vl, .lane_en
  );

  vloop_trackers #(.NREG(NREG), .OFF_W(OFF_W), .MAXVL(MAXVL),
                   .ELEM_BYTES(ELEM_BYTES)) trk_i (
    .clk, .rst_n, .clr(trk_clr), .adv(trk_adv), .vl, .vec_tag,
    .q_reg, .q_base
  );

  assign q_is_vec = vec_tag[q_reg];

  for (genvar i = 0; i < MAXVL; i++) begin : g_off
    assign lane_off[i*OFF_W +: OFF_W] = q_base + OFF_W'(i * ELEM_BYTES);
  end
endmodule

// File: rtl/vloop_seq_chk.sv
module vloop_seq_chk #(
  parameter int MAXVL = 20,
  parameter int CTR_W = 16,
  localparam int VL_W = $clog2(MAXVL + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             setup_valid,
  input logic             wr_valid,
  input logic             br_valid,
  input logic             active,
  input logic [VL_W-1:0]  vl,
  input logic [MAXVL-1:0] lane_en,
  input logic             br_taken,
  input logic [CTR_W-1:0] ctr_out,
  input logic             err
);
  AST_IDLE_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (vl == '0) && (lane_en == '0));                          // R5
  AST_VL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (VL_W'(MAXVL) >= vl) && (CTR_W'(vl) <= ctr_out));         // R5
  AST_MASK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_en) == int'(vl));                                    // R6
  AST_CTR_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && active && !setup_valid |=>
      ctr_out == $past(ctr_out) - CTR_W'($past(vl)));                    // R8
  AST_TAKEN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> active);                                                // R9
  AST_FALL_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && active && !setup_valid && !br_taken |=> !active);        // R10
  AST_ENTRY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(wr_valid));                                  // R3
  AST_ABORT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    setup_valid && active |=> err && !active);                           // R11
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);                                                       // R11
  AST_IDLE_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !br_taken);                                              // R12
endmodule

bind vloop_seq vloop_seq_chk #(.MAXVL(MAXVL), .CTR_W(CTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid), .wr_valid(wr_valid),
  .br_valid(br_valid), .active(active), .vl(vl), .lane_en(lane_en),
  .br_taken(br_taken), .ctr_out(ctr_out), .err(err)
);

// File: tb/vloop_seq_tb_top.sv
module vloop_seq_tb_top;
  localparam int NREG = 32, MAXVL = 20, CTR_W = 16, OFF_W = 16, EB = 4;
  localparam int IDX_W = $clog2(NREG), VL_W = $clog2(MAXVL + 1);

  // {initial counter, expected number of passes}
  localparam logic [31:0] TBL [6] = '{
    {16'd32, 16'd2}, {16'd20, 16'd1}, {16'd5, 16'd1},
    {16'd41, 16'd3}, {16'd60, 16'd3}, {16'd1, 16'd1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic setup_valid;
  logic [NREG-1:0] setup_vec_mask, setup_inv_mask;
  logic wr_valid;
  logic [IDX_W-1:0] wr_reg, q_reg;
  logic ctr_wr_valid;
  logic [CTR_W-1:0] ctr_wr_data;
  logic br_valid;
  logic active, q_is_vec, br_taken, err;
  logic [VL_W-1:0] vl;
  logic [MAXVL-1:0] lane_en;
  logic [MAXVL*OFF_W-1:0] lane_off;
  logic [CTR_W-1:0] ctr_out;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  vloop_seq dut_i (.*);

  task automatic chk(input longint act, input longint exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    setup_valid = 0; setup_vec_mask = '0; setup_inv_mask = '0;
    wr_valid = 0; wr_reg = '0; ctr_wr_valid = 0; ctr_wr_data = '0;
    br_valid = 0;
  endtask

  task automatic do_setup(input logic [NREG-1:0] v, input logic [NREG-1:0] i);
    @(negedge clk); setup_valid = 1; setup_vec_mask = v; setup_inv_mask = i;
    @(negedge clk); clear_in();
  endtask

  task automatic do_write(input int r);
    @(negedge clk); wr_valid = 1; wr_reg = IDX_W'(r);
    @(negedge clk); clear_in();
  endtask

  task automatic do_ctr(input int c);
    @(negedge clk); ctr_wr_valid = 1; ctr_wr_data = CTR_W'(c);
    @(negedge clk); clear_in();
  endtask

  task automatic do_branch(input int exp_taken, input string req);
    @(negedge clk); br_valid = 1; #1;
    chk(br_taken, exp_taken, req);
    @(negedge clk); clear_in();
  endtask

  function automatic int lane_field(input int i);
    return int'(lane_off[i*OFF_W +: OFF_W]);
  endfunction

  initial begin
    #(10 * 100000);
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_in();
    q_reg = IDX_W'(21);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(active, 0, "R1"); chk(vl, 0, "R1"); chk(lane_en, 0, "R1");
    chk(ctr_out, 0, "R1"); chk(err, 0, "R1"); chk(br_taken, 0, "R1");

    // Table walk: each entry is a full strip-mined loop
    foreach (TBL[k]) begin
      int rem, passes, consumed, v, tk;
      rem = int'(TBL[k][31:16]);
      passes = 0; consumed = 0;
      do_ctr(rem);
      chk(ctr_out, rem, "R12");
      do_setup((32'b1 << 20) | (32'b1 << 21) | (32'b1 << 22), 32'b1 << 7);
      chk(active, 0, "R2");
      do_write(20);
      chk(active, 1, "R3");
      while (active && passes < 10) begin
        v = (rem < MAXVL) ? rem : MAXVL;
        chk(vl, v, "R5");
        chk(lane_en, (longint'(1) << v) - 1, "R6");
        chk(lane_field(0), consumed * EB, (passes == 0) ? "R4" : "R9");
        chk(lane_field(v - 1), consumed * EB + (v - 1) * EB, "R7");
        tk = (rem != v);
        do_branch(tk, "R8");
        rem = rem - v; consumed = consumed + v; passes++;
        chk(ctr_out, rem, "R8");
        chk(active, tk, "R10");
      end
      chk(passes, int'(TBL[k][15:0]), "R9");
    end

    // R7: first-pass lane offsets 0,4,8,12
    do_ctr(32);
    do_write(21);
    chk(lane_field(1), 4, "R7"); chk(lane_field(2), 8, "R7");
    chk(lane_field(3), 12, "R7");
    // R12: counter write while active ignored
    do_ctr(7);
    chk(ctr_out, 32, "R12");
    // R11: setup while active aborts, pulses err for one cycle
    @(negedge clk); setup_valid = 1; setup_vec_mask = 32'b1 << 3;
    @(negedge clk); clear_in();
    chk(active, 0, "R11"); chk(err, 1, "R11");
    @(negedge clk);
    chk(err, 0, "R11");
    do_write(20);
    chk(active, 0, "R11");
    // R12: branch while inactive ignored
    do_branch(0, "R12");
    chk(ctr_out, 32, "R12");
    // R2/R3: invariant wins over vector tag; untagged write does nothing
    do_setup(32'b1 << 5, 32'b1 << 5);
    q_reg = IDX_W'(5);
    @(negedge clk);
    chk(q_is_vec, 0, "R2");
    do_write(5);
    chk(active, 0, "R3");
    do_write(9);
    chk(active, 0, "R3");
    // R5/R10: zero counter gives VL 0 and the loop exits at once
    do_setup(32'b1 << 9, '0);
    do_ctr(0);
    do_write(9);
    chk(active, 1, "R3"); chk(vl, 0, "R5");
    do_branch(0, "R10");
    chk(active, 0, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule